// File: doc/BRIEF.md
# CAN controller mode sequencer

This block is the top-level mode sequencer of a CAN protocol controller. It owns the reset-request control bit and the configuration-mode status flag, and it raises the reset interrupt flag. It decides when the controller may take part in bus traffic and, once it does, whether it acts as a transmitter or as a receiver for each frame. Bit framing, CRC, stuffing, bit-timing generation, mailbox storage and the timestamp timer are handled by neighbouring logic. The sequencer only reports whether the timer may be started.

After a power-on reset, or after software sets the reset bit, the controller stays in configuration mode. It does not drive or join the bus. Software programs bit timing and then clears the reset bit, and the sequencer moves to a synchronisation phase. In that phase it waits for a run of recessive bit samples before it joins the bus. While joined, a non-zero pending-transmit vector makes it a transmitter. Otherwise a start of frame seen on the bus makes it a receiver. If a transmitter loses arbitration, it becomes the receiver for that frame.

Top module: `can_mode_seq`

## Requirements
- R1: After power-on reset, rst_req=1, cfg_mode=1 and rst_irq=1, while bus_joined, role_tx, role_rx and tmr_start_ok are all 0.
- R2: A sw_rst_set pulse in any mode gives rst_req=1 and cfg_mode=1 in the next cycle, with bus_joined, role_tx and role_rx at 0. When the pulse arrives outside configuration mode, rst_irq is also set in that cycle.
- R3: While cfg_mode=1, or while the sequencer waits for bus idle, role_tx and role_rx stay 0 whatever tx_pend, bit_strobe and bus_bit do. While cfg_mode=1, bus_joined also stays 0.
- R4: A sw_rst_clr pulse clears rst_req only when timing_ok=1, and a clear with timing_ok=0 is ignored. If set and clear arrive in the same cycle, the set wins. cfg_mode drops one cycle after rst_req reads 0.
- R5: After configuration mode is left, bus_joined rises in the cycle after the IDLE_BITS-th consecutive bit_strobe sample with bus_bit=1 (recessive, default 11 samples). A bit_strobe sample with bus_bit=0 (dominant) restarts the count. Cycles without bit_strobe do not change the count.
- R6: While joined and idle, a non-zero tx_pend gives role_tx=1 in the next cycle. With tx_pend=0, a bit_strobe sample with bus_bit=0 gives role_rx=1 in the next cycle, and a recessive sample leaves the role idle. Transmission takes priority over reception.
- R7: An arb_lost pulse while role_tx=1 switches to role_rx=1 in the next cycle, and arb_lost is ignored in the other roles. A frame_done pulse returns the role to idle.
- R8: An irq_clr pulse clears rst_irq. If the flag is set and cleared in the same cycle, the set wins.
- R9: tmr_start_ok becomes 1 once both tmr_ctrl_wr and trig_wr have been seen since the last reset entry, and it may be written in any mode. Power-on reset and sw_rst_set clear the two write records, and a clear in the same cycle as a write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| sw_rst_set | input | 1 | Software write of 1 to the reset-request bit |
| sw_rst_clr | input | 1 | Software write of 0 to the reset-request bit |
| timing_ok | input | 1 | Bit timing has been programmed |
| irq_clr | input | 1 | Write-1-to-clear of the reset interrupt flag |
| bit_strobe | input | 1 | One-cycle bit sample strobe |
| bus_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| tx_pend | input | TX_SLOTS | Pending-transmit request per message slot |
| arb_lost | input | 1 | Arbitration lost by the frame engine |
| frame_done | input | 1 | Current frame finished |
| tmr_ctrl_wr | input | 1 | Timer control settings written |
| trig_wr | input | 1 | Transmit trigger time written |
| rst_req | output | 1 | Reset-request bit value |
| cfg_mode | output | 1 | Configuration-mode status flag |
| rst_irq | output | 1 | Reset interrupt flag |
| bus_joined | output | 1 | Controller takes part in bus activity |
| role_tx | output | 1 | Transmitter role for the current frame |
| role_rx | output | 1 | Receiver role for the current frame |
| tmr_start_ok | output | 1 | Timer start permitted |

## Verification
A software reset request can land in the same cycle as an interrupt-clear write, a lost arbitration and a timer-control write. Reset entry must then win every one of them: the interrupt flag ends up set, the role is idle rather than receiver, and the timer permission is 0. The bench drives all four pulses in one cycle while the controller is transmitting, and it compares the full output vector in the next cycle. A similar collision of a reset-bit set and clear in the same cycle is driven in configuration mode, where the set must win and the interrupt flag must stay cleared.

// File: rtl/can_seq_pkg.sv
package can_seq_pkg;
    typedef enum logic [1:0] {
        MODE_CFG    = 2'd0,
        MODE_SYNC   = 2'd1,
        MODE_ACTIVE = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        ROLE_IDLE = 2'd0,
        ROLE_RX   = 2'd1,
        ROLE_TX   = 2'd2
    } role_e;
endpackage

// File: rtl/can_idle_detect.sv
module can_idle_detect #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic strobe,
    input  logic bus_bit,
    output logic done
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LAST = CW'(IDLE_BITS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = 1'b0;
        if (!enable) begin
            s_d.cnt = '0;
        end else if (strobe) begin
            if (!bus_bit) begin
                s_d.cnt = '0;
            end else if (s_q.cnt == LAST) begin
                done    = 1'b1;
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/can_role_arb.sv
module can_role_arb
    import can_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic abort,
    input  logic tx_any,
    input  logic strobe,
    input  logic bus_bit,
    input  logic arb_lost,
    input  logic frame_done,
    output logic role_tx,
    output logic role_rx
);
    typedef struct packed {
        role_e role;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!active || abort) begin
            s_d.role = ROLE_IDLE;
        end else begin
            unique case (s_q.role)
                ROLE_IDLE: begin
                    if (tx_any)                  s_d.role = ROLE_TX;
                    else if (strobe && !bus_bit) s_d.role = ROLE_RX;
                end
                ROLE_TX: begin
                    if (arb_lost)        s_d.role = ROLE_RX;
                    else if (frame_done) s_d.role = ROLE_IDLE;
                end
                ROLE_RX: begin
                    if (frame_done) s_d.role = ROLE_IDLE;
                end
                default: s_d.role = ROLE_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{role: ROLE_IDLE};
        else        s_q <= s_d;
    end

    assign role_tx = (s_q.role == ROLE_TX);
    assign role_rx = (s_q.role == ROLE_RX);
endmodule

// File: rtl/can_rstbit_ctrl.sv
module can_rstbit_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    input  logic timing_ok,
    input  logic irq_clr,
    input  logic enter_cfg,
    output logic rst_bit,
    output logic irq_flag
);
    typedef struct packed {
        logic rst_bit;
        logic irq;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_req && timing_ok) s_d.rst_bit = 1'b0;
        if (set_req)              s_d.rst_bit = 1'b1;
        if (irq_clr)              s_d.irq     = 1'b0;
        if (enter_cfg)            s_d.irq     = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{rst_bit: 1'b1, irq: 1'b1};
        else        s_q <= s_d;
    end

    assign rst_bit  = s_q.rst_bit;
    assign irq_flag = s_q.irq;
endmodule

// File: rtl/can_tmr_gate.sv
module can_tmr_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic trig_wr,
    input  logic clear,
    output logic permit
);
    typedef struct packed {
        logic ctrl_seen;
        logic trig_seen;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ctrl_wr) s_d.ctrl_seen = 1'b1;
        if (trig_wr) s_d.trig_seen = 1'b1;
        if (clear)   s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign permit = s_q.ctrl_seen && s_q.trig_seen;
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq
    import can_seq_pkg::*;
#(
    parameter int TX_SLOTS  = 16,
    parameter int IDLE_BITS = 11
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sw_rst_set,
    input  logic                sw_rst_clr,
    input  logic                timing_ok,
    input  logic                irq_clr,
    input  logic                bit_strobe,
    input  logic                bus_bit,
    input  logic [TX_SLOTS-1:0] tx_pend,
    input  logic                arb_lost,
    input  logic                frame_done,
    input  logic                tmr_ctrl_wr,
    input  logic                trig_wr,
    output logic                rst_req,
    output logic                cfg_mode,
    output logic                rst_irq,
    output logic                bus_joined,
    output logic                role_tx,
    output logic                role_rx,
    output logic                tmr_start_ok
);
    typedef struct packed {
        mode_e mode;
    } st_t;

    st_t  s_d, s_q;
    logic rst_bit;
    logic idle_done;
    logic enter_cfg;
    logic tx_any;

    assign tx_any    = |tx_pend;
    assign enter_cfg = sw_rst_set && (s_q.mode != MODE_CFG);

    can_rstbit_ctrl u_rstbit (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_req   (sw_rst_set),
        .clr_req   (sw_rst_clr),
        .timing_ok (timing_ok),
        .irq_clr   (irq_clr),
        .enter_cfg (enter_cfg),
        .rst_bit   (rst_bit),
        .irq_flag  (rst_irq)
    );

    can_idle_detect #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (s_q.mode == MODE_SYNC),
        .strobe  (bit_strobe),
        .bus_bit (bus_bit),
        .done    (idle_done)
    );

    can_role_arb u_role (
        .clk        (clk),
        .rst_n      (rst_n),
        .active     (s_q.mode == MODE_ACTIVE),
        .abort      (sw_rst_set),
        .tx_any     (tx_any),
        .strobe     (bit_strobe),
        .bus_bit    (bus_bit),
        .arb_lost   (arb_lost),
        .frame_done (frame_done),
        .role_tx    (role_tx),
        .role_rx    (role_rx)
    );

    can_tmr_gate u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (tmr_ctrl_wr),
        .trig_wr (trig_wr),
        .clear   (sw_rst_set),
        .permit  (tmr_start_ok)
    );

    always_comb begin
        s_d = s_q;
        if (sw_rst_set) begin
            s_d.mode = MODE_CFG;
        end else begin
            unique case (s_q.mode)
                MODE_CFG:    if (!rst_bit)  s_d.mode = MODE_SYNC;
                MODE_SYNC:   if (idle_done) s_d.mode = MODE_ACTIVE;
                MODE_ACTIVE: s_d.mode = MODE_ACTIVE;
                default:     s_d.mode = MODE_CFG;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_CFG};
        else        s_q <= s_d;
    end

    assign rst_req    = rst_bit;
    assign cfg_mode   = (s_q.mode == MODE_CFG);
    assign bus_joined = (s_q.mode == MODE_ACTIVE);
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sw_rst_set,
    input logic timing_ok,
    input logic irq_clr,
    input logic bit_strobe,
    input logic bus_bit,
    input logic arb_lost,
    input logic rst_req,
    input logic cfg_mode,
    input logic rst_irq,
    input logic bus_joined,
    input logic role_tx,
    input logic role_rx,
    input logic tmr_start_ok
);
    p_swset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_set |=> rst_req && cfg_mode && !bus_joined && !role_tx && !role_rx);

    p_entry_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_set && !cfg_mode |=> rst_irq);

    p_cfg_no_role_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_mode |-> !bus_joined && !role_tx && !role_rx);

    p_clr_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req && !timing_ok |=> rst_req);

    p_join_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_joined) |-> $past(bit_strobe) && $past(bus_bit));

    p_arb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        role_tx && arb_lost && !sw_rst_set |=> role_rx);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_irq && !irq_clr |=> rst_irq);

    p_tmr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst_set |=> !tmr_start_ok);
endmodule

bind can_mode_seq can_mode_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_rst_set   (sw_rst_set),
    .timing_ok    (timing_ok),
    .irq_clr      (irq_clr),
    .bit_strobe   (bit_strobe),
    .bus_bit      (bus_bit),
    .arb_lost     (arb_lost),
    .rst_req      (rst_req),
    .cfg_mode     (cfg_mode),
    .rst_irq      (rst_irq),
    .bus_joined   (bus_joined),
    .role_tx      (role_tx),
    .role_rx      (role_rx),
    .tmr_start_ok (tmr_start_ok)
);

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
    localparam int TX_SLOTS = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sw_rst_set = 0, sw_rst_clr = 0, timing_ok = 0, irq_clr = 0;
    logic bit_strobe = 0, bus_bit = 1, arb_lost = 0, frame_done = 0;
    logic tmr_ctrl_wr = 0, trig_wr = 0;
    logic [TX_SLOTS-1:0] tx_pend = '0;
    logic rst_req, cfg_mode, rst_irq, bus_joined, role_tx, role_rx, tmr_start_ok;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [6:0] exp;
    } item_t;
    item_t sb_q[$];

    always #10 clk = ~clk;

    can_mode_seq #(.TX_SLOTS(TX_SLOTS), .IDLE_BITS(11)) dut (
        .clk(clk), .rst_n(rst_n), .sw_rst_set(sw_rst_set), .sw_rst_clr(sw_rst_clr),
        .timing_ok(timing_ok), .irq_clr(irq_clr), .bit_strobe(bit_strobe),
        .bus_bit(bus_bit), .tx_pend(tx_pend), .arb_lost(arb_lost),
        .frame_done(frame_done), .tmr_ctrl_wr(tmr_ctrl_wr), .trig_wr(trig_wr),
        .rst_req(rst_req), .cfg_mode(cfg_mode), .rst_irq(rst_irq),
        .bus_joined(bus_joined), .role_tx(role_tx), .role_rx(role_rx),
        .tmr_start_ok(tmr_start_ok)
    );

    // Vector order: rst_req, cfg_mode, rst_irq, bus_joined, role_tx, role_rx, tmr_start_ok
    task automatic expect_out(input string tag, input logic [6:0] exp);
        item_t it;
        it.tag = tag;
        it.exp = exp;
        sb_q.push_back(it);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        sw_rst_set = 0; sw_rst_clr = 0; irq_clr = 0; bit_strobe = 0;
        arb_lost = 0; frame_done = 0; tmr_ctrl_wr = 0; trig_wr = 0;
    endtask

    task automatic strobe_bit(input logic b);
        bit_strobe = 1'b1;
        bus_bit    = b;
        tick();
    endtask

    // Monitor: compare queued expectations away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [6:0] act;
                it  = sb_q.pop_front();
                act = {rst_req, cfg_mode, rst_irq, bus_joined, role_tx, role_rx, tmr_start_ok};
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;
        tick();
        expect_out("R1 power-on state", 7'b1110000);

        // R3: no role in configuration despite pending transmit and bus activity
        tx_pend = 16'h0008;
        strobe_bit(1'b0);
        expect_out("R3 config ignores tx_pend/bus", 7'b1110000);

        // R4: clear without timing is ignored
        timing_ok = 0; sw_rst_clr = 1; tick();
        expect_out("R4 clear ignored without timing", 7'b1110000);

        // R8: write-1-clear of the interrupt flag
        irq_clr = 1; tick();
        expect_out("R8 irq cleared", 7'b1100000);

        // R4: set and clear together, set wins; R2: no irq since already in config
        timing_ok = 1; sw_rst_set = 1; sw_rst_clr = 1; tick();
        expect_out("R4 set wins over clear (R2 no irq in config)", 7'b1100000);

        sw_rst_clr = 1; tick();
        expect_out("R4 reset bit cleared", 7'b0100000);
        tick();
        expect_out("R4 cfg flag drops a cycle later", 7'b0000000);

        // R5: count restarts on a dominant strobe sample
        for (int i = 0; i < 7; i++) strobe_bit(1'b1);
        strobe_bit(1'b0);
        expect_out("R3 no role while waiting for idle", 7'b0000000);
        for (int i = 0; i < 10; i++) strobe_bit(1'b1);
        expect_out("R5 ten recessive not enough", 7'b0000000);
        bus_bit = 1'b0; tick();
        expect_out("R5 non-strobe cycle ignored", 7'b0000000);
        strobe_bit(1'b1);
        expect_out("R5 joined after eleventh", 7'b0001000);

        // R6: transmit has priority over a start of frame
        bit_strobe = 1; bus_bit = 0; tick();
        expect_out("R6 tx priority", 7'b0001100);

        arb_lost = 1; tick();
        expect_out("R7 arbitration lost to rx", 7'b0001010);
        arb_lost = 1; tick();
        expect_out("R7 arb_lost ignored in rx", 7'b0001010);
        frame_done = 1; tick();
        expect_out("R7 frame done to idle", 7'b0001000);

        tx_pend = '0;
        strobe_bit(1'b1);
        expect_out("R6 recessive sample stays idle", 7'b0001000);
        strobe_bit(1'b0);
        expect_out("R6 start of frame gives rx", 7'b0001010);
        frame_done = 1; tick();
        expect_out("R7 rx frame done", 7'b0001000);

        tx_pend = 16'h8000; tick();
        expect_out("R6 top slot pending gives tx", 7'b0001100);
        tx_pend = '0; frame_done = 1; tick();
        expect_out("R7 tx frame done", 7'b0001000);

        // R9: timer permission needs both writes
        tmr_ctrl_wr = 1; tick();
        expect_out("R9 control write alone", 7'b0001000);
        trig_wr = 1; tick();
        expect_out("R9 both writes", 7'b0001001);

        tx_pend = 16'h0001; tick();
        expect_out("R6 tx with permit", 7'b0001101);

        // Collision: reset entry with irq clear, arb loss and timer write
        sw_rst_set = 1; irq_clr = 1; arb_lost = 1; tmr_ctrl_wr = 1; tick();
        expect_out("R2 R8 R9 reset entry wins collision", 7'b1110000);

        trig_wr = 1; tick();
        expect_out("R9 trig alone after reset", 7'b1110000);
        tmr_ctrl_wr = 1; tick();
        expect_out("R9 permit in config", 7'b1110001);
        tick();
        expect_out("R3 still no role in config", 7'b1110001);

        repeat (3) @(posedge clk);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule